// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sits beside a small 8-bit microcontroller core. It takes care of the core's sleep states. It divides the raw oscillator input by two to form the internal clock. From that clock it derives three gated clock enables: one for the CPU, one for the timers and interrupt logic, and one for the analog converter and PWM peripherals. It also drives a run signal back to the oscillator.

The CPU writes a mode request into a power control register. Setting the idle request stops the CPU clock and the converter/PWM clock, while the timers and interrupt logic keep running. Any interrupt that is both pending and enabled ends idle mode. The block then raises a wake-vector request that tells the CPU which source woke it, so the CPU can resume at that source's service routine.

Setting the power-down request stops the oscillator, and with it every derived clock. Only the hardware reset leaves power-down. After reset, and after an idle wake, a reference-ready flag stays low for a programmable number of divided clocks. Software uses this flag to wait until the analog reference has settled before it starts a conversion.

Top module: `lp_clk_ctrl`

## Requirements
- R1: While the oscillator runs, `divClk` inverts on every rising edge of `oscIn`. It is 0 out of reset. A "tick" is the `oscIn` edge at which `divClk` goes from 1 to 0, which is every second edge after reset release.
- R2: While `rstN` is low and right after it rises, `cpuClkEn`, `tmrClkEn`, `anaClkEn` and `oscRun` are 1, and `wakeReq`, `refReady` and `divClk` are 0.
- R3: In run mode, a write at a tick to address `PCON_ADDR` (default 0x87) with data bit 0 set and bit 1 clear enters idle. Idle means `cpuClkEn`=0, `anaClkEn`=0, `tmrClkEn`=1 and `oscRun`=1.
- R4: In run mode, a write at a tick to `PCON_ADDR` with data bit 1 set enters power-down, whatever bit 0 holds. Power-down means every enable and `oscRun` are 0, and `divClk` stays frozen.
- R5: A write to any other address, or a write whose bits 1:0 are both 0, leaves run mode and every output unchanged. Data bits 7:2 have no effect.
- R6: Power control writes are ignored while the CPU clock is stopped. A write with bit 1 set, made during idle, does not enter power-down.
- R7: In idle, at a tick where `irqReq & irqEn` is non-zero, the block returns to run mode. At the same time it raises `wakeReq` for exactly one divided-clock period, with `wakeSrc` set to the lowest index among the enabled pending sources. Pending sources that are not enabled do not wake the block.
- R8: In power-down, interrupts have no effect. Only `rstN` low ends power-down, and after it the block is in the reset state.
- R9: A reset asserted during idle returns the block to the reset state of R2.
- R10: The clock enables change only at ticks, that is, on the falling phase of `divClk`.
- R11: `refReady` is 0 in idle and in power-down. After reset release, or after an idle-wake tick, it stays 0 through the next `settleTicks`+1 ticks and becomes 1 after the last of them.
- R12: In run mode, pending enabled interrupts never raise `wakeReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscIn | input | 1 | Raw oscillator input; every register uses its rising edge |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| sfrWe | input | 1 | Register write strobe from the CPU |
| sfrAddr | input | ADDR_W | Register write address |
| sfrWdata | input | DATA_W | Register write data; bit 0 requests idle, bit 1 requests power-down |
| irqReq | input | IRQ_CNT | Pending interrupt requests, one per source |
| irqEn | input | IRQ_CNT | Per-source interrupt enables |
| settleTicks | input | SETTLE_W | Reference settling length, in divided clocks |
| divClk | output | 1 | Divided-by-two internal clock |
| oscRun | output | 1 | Oscillator run request |
| cpuClkEn | output | 1 | CPU clock enable |
| tmrClkEn | output | 1 | Timer and interrupt logic clock enable |
| anaClkEn | output | 1 | Converter and PWM clock enable |
| wakeReq | output | 1 | Wake-vector request to the CPU, one divided period long |
| wakeSrc | output | IDX_W | Index of the interrupt source that caused the wake |
| refReady | output | 1 | Analog reference settled; a conversion may start |

## Verification
Some properties are checked on every cycle. The enables may move only right after a tick. The timer enable covers the CPU enable. A wake request only appears with the CPU clock running. The reference flag implies the converter clock. The divider stays frozen with the oscillator off. A power-down request, once latched, never clears without reset. A wake pulse ends at the following tick.

Other behaviour only the bench scenarios can show. These are the mode chosen for each combination of address and data bits, the priority choice of `wakeSrc` across every request pattern under two enable masks, and the exact tick on which `refReady` rises. They also cover the ignored writes during idle, and the fact that power-down survives interrupts but yields to reset.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PD   = 2'd2
  } lpMode_t;

  // strobes from control to datapath, all valid only on a tick
  typedef struct packed {
    logic takeWrite;  // latch the power control bits
    logic wake;       // idle exit: clear idle bit, raise wake request
    logic armSettle;  // restart the reference settling window
  } lpStrobe_t;

endpackage

// File: rtl/lpc_datapath.sv
module lpc_datapath
  import lpc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int IRQ_CNT   = 5,
  parameter int SETTLE_W  = 8,
  parameter logic [ADDR_W-1:0] PCON_ADDR = 8'h87,
  localparam int IDX_W    = (IRQ_CNT > 1) ? $clog2(IRQ_CNT) : 1
) (
  input  logic                oscIn,
  input  logic                rstN,
  input  logic                oscRun,
  input  logic                modeRun,
  input  lpStrobe_t           stb,
  input  logic                sfrWe,
  input  logic [ADDR_W-1:0]   sfrAddr,
  input  logic [DATA_W-1:0]   sfrWdata,
  input  logic [IRQ_CNT-1:0]  irqReq,
  input  logic [IRQ_CNT-1:0]  irqEn,
  input  logic [SETTLE_W-1:0] settleTicks,
  output logic                tick,
  output logic                divClk,
  output logic                wrHit,
  output logic                wrIdle,
  output logic                wrPd,
  output logic                irqHit,
  output logic                pdBit,
  output logic                wakeReq,
  output logic [IDX_W-1:0]    wakeSrc,
  output logic                refReady
);

  logic                divPhase;
  logic                idleBit;
  logic                pdBitQ;
  logic                settleArm;
  logic [SETTLE_W-1:0] settleCnt;
  logic [IRQ_CNT-1:0]  pend;
  logic [IDX_W-1:0]    irqIdx;
  logic                wakeQ;
  logic [IDX_W-1:0]    srcQ;

  // divide-by-two: toggles on every oscillator edge while running
  always_ff @(posedge oscIn or negedge rstN) begin
    if (!rstN)       divPhase <= 1'b0;
    else if (oscRun) divPhase <= ~divPhase;
  end

  assign divClk = divPhase;
  assign tick   = divPhase & oscRun;

  // write decode
  assign wrHit  = sfrWe && (sfrAddr == PCON_ADDR);
  assign wrIdle = sfrWdata[0];
  assign wrPd   = sfrWdata[1];

  // power control bits
  always_ff @(posedge oscIn or negedge rstN) begin
    if (!rstN) begin
      idleBit <= 1'b0;
      pdBitQ  <= 1'b0;
    end else if (tick) begin
      if (stb.takeWrite) begin
        idleBit <= sfrWdata[0];
        pdBitQ  <= sfrWdata[1];
      end else if (stb.wake) begin
        idleBit <= 1'b0;
      end
    end
  end

  assign pdBit = pdBitQ;

  // lowest index of enabled pending sources wins
  assign pend   = irqReq & irqEn;
  assign irqHit = |pend;

  always_comb begin
    irqIdx = '0;
    for (int i = IRQ_CNT - 1; i >= 0; i--) begin
      if (pend[i]) irqIdx = IDX_W'(i);
    end
  end

  // wake request: one divided period
  always_ff @(posedge oscIn or negedge rstN) begin
    if (!rstN) begin
      wakeQ <= 1'b0;
      srcQ  <= '0;
    end else if (tick) begin
      wakeQ <= stb.wake;
      if (stb.wake) srcQ <= irqIdx;
    end
  end

  assign wakeReq = wakeQ;
  assign wakeSrc = srcQ;

  // reference settling window
  always_ff @(posedge oscIn or negedge rstN) begin
    if (!rstN) begin
      settleArm <= 1'b1;
      settleCnt <= '0;
    end else if (tick) begin
      if (stb.armSettle) begin
        settleArm <= 1'b1;
      end else if (settleArm) begin
        settleArm <= 1'b0;
        settleCnt <= settleTicks;
      end else if (settleCnt != '0) begin
        settleCnt <= settleCnt - 1'b1;
      end
    end
  end

  assign refReady = modeRun && !settleArm && (settleCnt == '0);

  // R8
  pd_sticky_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    pdBitQ |=> pdBitQ);

  // R7
  wake_pulse_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    (wakeQ && tick) |=> !wakeQ);

  // R11
  settle_idle_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    idleBit |-> !refReady);

endmodule

// File: rtl/lpc_control.sv
module lpc_control
  import lpc_pkg::*;
(
  input  logic      oscIn,
  input  logic      rstN,
  input  logic      tick,
  input  logic      wrHit,
  input  logic      wrIdle,
  input  logic      wrPd,
  input  logic      irqHit,
  output lpStrobe_t stb,
  output lpMode_t   mode,
  output logic      cpuClkEn,
  output logic      tmrClkEn,
  output logic      anaClkEn,
  output logic      oscRun
);

  lpMode_t modeQ;
  lpMode_t modeD;

  always_comb begin
    stb   = '0;
    modeD = modeQ;
    if (tick) begin
      unique case (modeQ)
        MODE_RUN: begin
          if (wrHit) begin
            stb.takeWrite = 1'b1;
            if (wrPd)        modeD = MODE_PD;
            else if (wrIdle) modeD = MODE_IDLE;
          end
        end
        MODE_IDLE: begin
          if (irqHit) begin
            stb.wake      = 1'b1;
            stb.armSettle = 1'b1;
            modeD         = MODE_RUN;
          end
        end
        default: modeD = modeQ;
      endcase
    end
  end

  always_ff @(posedge oscIn or negedge rstN) begin
    if (!rstN) modeQ <= MODE_RUN;
    else       modeQ <= modeD;
  end

  assign mode     = modeQ;
  assign cpuClkEn = (modeQ == MODE_RUN);
  assign anaClkEn = (modeQ == MODE_RUN);
  assign tmrClkEn = (modeQ != MODE_PD);
  assign oscRun   = (modeQ != MODE_PD);

  // R8
  pd_hold_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    (modeQ == MODE_PD) |=> (modeQ == MODE_PD));

  // R6
  idle_no_pd_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    (modeQ == MODE_IDLE) |=> (modeQ != MODE_PD));

endmodule

// File: rtl/lp_clk_ctrl.sv
module lp_clk_ctrl
  import lpc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int IRQ_CNT   = 5,
  parameter int SETTLE_W  = 8,
  parameter logic [ADDR_W-1:0] PCON_ADDR = 8'h87,
  localparam int IDX_W    = (IRQ_CNT > 1) ? $clog2(IRQ_CNT) : 1
) (
  input  logic                oscIn,
  input  logic                rstN,
  input  logic                sfrWe,
  input  logic [ADDR_W-1:0]   sfrAddr,
  input  logic [DATA_W-1:0]   sfrWdata,
  input  logic [IRQ_CNT-1:0]  irqReq,
  input  logic [IRQ_CNT-1:0]  irqEn,
  input  logic [SETTLE_W-1:0] settleTicks,
  output logic                divClk,
  output logic                oscRun,
  output logic                cpuClkEn,
  output logic                tmrClkEn,
  output logic                anaClkEn,
  output logic                wakeReq,
  output logic [IDX_W-1:0]    wakeSrc,
  output logic                refReady
);

  lpStrobe_t stb;
  lpMode_t   mode;
  logic      tick;
  logic      wrHit;
  logic      wrIdle;
  logic      wrPd;
  logic      irqHit;
  logic      pdBit;

  lpc_control u_ctrl (
    .oscIn    (oscIn),
    .rstN     (rstN),
    .tick     (tick),
    .wrHit    (wrHit),
    .wrIdle   (wrIdle),
    .wrPd     (wrPd),
    .irqHit   (irqHit),
    .stb      (stb),
    .mode     (mode),
    .cpuClkEn (cpuClkEn),
    .tmrClkEn (tmrClkEn),
    .anaClkEn (anaClkEn),
    .oscRun   (oscRun)
  );

  lpc_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IRQ_CNT   (IRQ_CNT),
    .SETTLE_W  (SETTLE_W),
    .PCON_ADDR (PCON_ADDR)
  ) u_dp (
    .oscIn       (oscIn),
    .rstN        (rstN),
    .oscRun      (oscRun),
    .modeRun     (mode == MODE_RUN),
    .stb         (stb),
    .sfrWe       (sfrWe),
    .sfrAddr     (sfrAddr),
    .sfrWdata    (sfrWdata),
    .irqReq      (irqReq),
    .irqEn       (irqEn),
    .settleTicks (settleTicks),
    .tick        (tick),
    .divClk      (divClk),
    .wrHit       (wrHit),
    .wrIdle      (wrIdle),
    .wrPd        (wrPd),
    .irqHit      (irqHit),
    .pdBit       (pdBit),
    .wakeReq     (wakeReq),
    .wakeSrc     (wakeSrc),
    .refReady    (refReady)
  );

  // R10
  cpu_en_edge_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    !$stable(cpuClkEn) |-> $past(tick));

  // R10
  tmr_en_edge_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    !$stable(tmrClkEn) |-> $past(tick));

  // R10
  ana_en_edge_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    !$stable(anaClkEn) |-> $past(tick));

  // R3
  tmr_cover_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    cpuClkEn |-> tmrClkEn);

  // R7
  wake_cpu_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    wakeReq |-> cpuClkEn);

  // R11
  ready_ana_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    refReady |-> anaClkEn);

  // R4
  pd_match_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    pdBit == !oscRun);

  // R4
  div_frozen_chk: assert property (@(posedge oscIn) disable iff (!rstN)
    !oscRun |=> $stable(divClk));

endmodule

// File: tb/sim_lp_clk_ctrl.sv
`timescale 1ns/1ps
module sim_lp_clk_ctrl;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int IRQS   = 5;
  localparam int SW     = 8;
  localparam int S      = 3;
  localparam int IW     = $clog2(IRQS);
  localparam logic [7:0] PADDR = 8'h87;

  logic oscIn = 1'b0;
  logic rstN  = 1'b0;
  logic sfrWe = 1'b0;
  logic [ADDR_W-1:0] sfrAddr = '0;
  logic [DATA_W-1:0] sfrWdata = '0;
  logic [IRQS-1:0] irqReq = '0;
  logic [IRQS-1:0] irqEn = '0;
  logic [SW-1:0] settleTicks = SW'(S);
  logic divClk, oscRun, cpuClkEn, tmrClkEn, anaClkEn, wakeReq, refReady;
  logic [IW-1:0] wakeSrc;

  int checks = 0;
  int fails  = 0;

  always #2.5 oscIn = ~oscIn;

  lp_clk_ctrl u0 (
    .oscIn(oscIn), .rstN(rstN), .sfrWe(sfrWe), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .irqReq(irqReq), .irqEn(irqEn),
    .settleTicks(settleTicks), .divClk(divClk), .oscRun(oscRun),
    .cpuClkEn(cpuClkEn), .tmrClkEn(tmrClkEn), .anaClkEn(anaClkEn),
    .wakeReq(wakeReq), .wakeSrc(wakeSrc), .refReady(refReady)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // enables packed as {cpu, tmr, ana, oscRun}
  function automatic int ens();
    return {28'd0, cpuClkEn, tmrClkEn, anaClkEn, oscRun};
  endfunction

  localparam int EN_RUN  = 4'b1111;
  localparam int EN_IDLE = 4'b0101;
  localparam int EN_PD   = 4'b0000;

  task automatic ticks(input int n);
    repeat (2 * n) @(negedge oscIn);
  endtask

  task automatic doReset();
    @(negedge oscIn);
    rstN = 1'b0; sfrWe = 1'b0; irqReq = '0; irqEn = '0;
    repeat (3) @(negedge oscIn);
    rstN = 1'b1;
  endtask

  task automatic pconWrite(input logic [7:0] a, input logic [7:0] d);
    sfrWe = 1'b1; sfrAddr = a; sfrWdata = d;
    ticks(1);
    sfrWe = 1'b0;
  endtask

  function automatic int lowBit(input int v);
    for (int i = 0; i < IRQS; i++) if (v[i]) return i;
    return 0;
  endfunction

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R2 during reset
    repeat (2) @(negedge oscIn);
    chk(ens() == EN_RUN && !wakeReq && !refReady && !divClk, "R2 in reset",
        ens(), EN_RUN);
    doReset();
    chk(ens() == EN_RUN && !wakeReq && !refReady && !divClk, "R2 after release",
        ens(), EN_RUN);

    // R1 divider phases
    for (int k = 1; k <= 4; k++) begin
      @(negedge oscIn);
      chk(divClk == k[0], "R1 divClk", divClk, k % 2);
    end

    // R11 settle after reset
    doReset();
    for (int k = 1; k <= S + 1; k++) begin
      ticks(1);
      chk(refReady == (k == S + 1), "R11 settle after reset", refReady, int'(k == S + 1));
    end

    // R3 R4 R5 write sweep
    for (int d = 0; d < 8; d++) begin
      for (int a = 0; a < 2; a++) begin
        logic [7:0] addr, data;
        int exp;
        addr = (a == 0) ? PADDR : PADDR + 8'd1;
        data = {d[2], 5'b0, d[1:0]};
        exp  = (a != 0) ? EN_RUN : (d[1] ? EN_PD : (d[0] ? EN_IDLE : EN_RUN));
        doReset();
        ticks(S + 1);
        sfrWe = 1'b1; sfrAddr = addr; sfrWdata = data;
        @(negedge oscIn);
        chk(ens() == EN_RUN, "R10 no change before tick", ens(), EN_RUN);
        @(negedge oscIn);
        sfrWe = 1'b0;
        chk(ens() == exp, (exp == EN_PD) ? "R4 mode" : (exp == EN_IDLE) ? "R3 mode" : "R5 mode",
            ens(), exp);
        chk(refReady == (exp == EN_RUN), "R11 ready by mode", refReady, int'(exp == EN_RUN));
        if (exp == EN_PD) begin
          logic frz;
          frz = divClk;
          irqEn = '1; irqReq = '1;
          ticks(3);
          chk(divClk == frz, "R4 divClk frozen", divClk, frz);
          chk(ens() == EN_PD && !wakeReq, "R8 irq ignored in pd", ens(), EN_PD);
          irqReq = '0;
          doReset();
          chk(ens() == EN_RUN && !wakeReq, "R8 reset leaves pd", ens(), EN_RUN);
        end
      end
    end

    // R7 wake sweep under two enable masks
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 32; r++) begin
        int en, hit;
        en  = (m == 0) ? 5'b10110 : 5'b11111;
        hit = r & en;
        doReset();
        ticks(S + 1);
        pconWrite(PADDR, 8'h01);
        irqEn = en[IRQS-1:0]; irqReq = r[IRQS-1:0];
        ticks(1);
        if (hit != 0) begin
          chk(ens() == EN_RUN && wakeReq, "R7 wake", ens(), EN_RUN);
          chk(wakeSrc == lowBit(hit), "R7 wakeSrc", wakeSrc, lowBit(hit));
          irqReq = '0;
          ticks(1);
          chk(!wakeReq, "R7 wake pulse one period", wakeReq, 0);
        end else begin
          chk(ens() == EN_IDLE && !wakeReq, "R7 no wake when masked", ens(), EN_IDLE);
        end
      end
    end

    // R11 settle after idle wake
    doReset();
    ticks(S + 1);
    pconWrite(PADDR, 8'h01);
    irqEn = 5'b00001; irqReq = 5'b00001;
    ticks(1);
    irqReq = '0;
    for (int k = 1; k <= S + 1; k++) begin
      ticks(1);
      chk(refReady == (k == S + 1), "R11 settle after wake", refReady, int'(k == S + 1));
    end

    // R6 writes ignored while idle
    doReset();
    ticks(S + 1);
    pconWrite(PADDR, 8'h01);
    pconWrite(PADDR, 8'h02);
    ticks(1);
    chk(ens() == EN_IDLE, "R6 pd write ignored in idle", ens(), EN_IDLE);
    irqEn = 5'b01000; irqReq = 5'b01000;
    ticks(1);
    irqReq = '0;
    chk(ens() == EN_RUN && wakeSrc == 3, "R6 wake after ignored write", ens(), EN_RUN);

    // R9 reset during idle
    doReset();
    ticks(2);
    pconWrite(PADDR, 8'h01);
    chk(ens() == EN_IDLE, "R9 in idle", ens(), EN_IDLE);
    doReset();
    chk(ens() == EN_RUN && !refReady && !wakeReq && !divClk, "R9 reset from idle",
        ens(), EN_RUN);

    // R12 interrupts in run mode
    doReset();
    ticks(S + 1);
    irqEn = '1; irqReq = 5'b10101;
    for (int k = 0; k < 3; k++) begin
      ticks(1);
      chk(!wakeReq && ens() == EN_RUN, "R12 no wake in run", wakeReq, 0);
    end
    irqReq = '0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule